// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column addresses of one SDRAM read or write burst, one column per accepted beat. A start pulse loads a starting column, a burst-length code and an ordering bit. The block then steps through the burst. For fixed lengths the addresses stay inside the aligned block whose size is the burst length. The upper column bits name that block and the low bits give the first column inside it. The order inside the block is either sequential with wrap, or interleaved, where beat k takes the start offset XOR k. A full-row burst walks the whole row in sequence, wraps from the last column to column 0, and runs until it is terminated.

Addresses leave as a valid/ready stream. `col_valid` high with `col_addr` means a column is offered. A beat is consumed on a rising edge where `col_valid` and `out_ready` are both high. While `out_ready` is low the offered column and `col_last` hold unchanged. `start` and `terminate` are plain control pins that act whatever the state of `out_ready`. `start` has priority over `terminate`.

Top module: `burst_colgen`

## Requirements
- R1: After reset, `col_valid` and `col_last` are low until a start is sampled.
- R2: On the clock edge that samples `start`, the block loads the burst. From then on `col_valid` is high and `col_addr` equals `start_col`.
- R3: `burst_len` codes 001, 010 and 011 select bursts of 2, 4 and 8 columns. With `burst_ilv`=0, the low log2(length) bits count up from the start offset and wrap inside the block, and the upper bits stay fixed. For example, length 4 with start offset 2 gives 2,3,0,1.
- R4: With `burst_ilv`=1 and length 2, 4 or 8, beat k carries the start offset XOR k in its low bits, and the upper bits stay fixed. For example, length 8 with start offset 3 gives 3,2,1,0,7,6,5,4.
- R5: Code 000 is a single-column burst. Only `start_col` is offered, `col_last` is high on that beat, and `burst_ilv` has no effect.
- R6: Code 111 is a full-row burst over 2^COL_W columns. Columns go up by one per beat and wrap from the top column to 0. `burst_ilv` is ignored, `col_last` never asserts, and the burst continues until terminated or restarted.
- R7: `col_last` is high only on the final beat of a fixed-length burst. Once that beat is accepted, `col_valid` is low after the edge unless a start is sampled on the same edge.
- R8: While `col_valid` is high and `out_ready` is low, `col_addr`, `col_last` and `col_valid` hold until the beat is accepted, terminated or restarted.
- R9: A sampled `terminate` without `start` makes `col_valid` low after that edge.
- R10: A `start` sampled during an active burst abandons it and begins the new burst from the new `start_col` after that edge.
- R11: The unused codes 100, 101 and 110 behave as a single-column burst.
- R12: Length and ordering are captured at start. Changes on `burst_len` or `burst_ilv` during a burst do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a burst with the current configuration |
| start_col | input | COL_W | First column of the burst |
| burst_len | input | 3 | Length code: 000=1, 001=2, 010=4, 011=8, 111=full row |
| burst_ilv | input | 1 | Ordering: 0 sequential, 1 interleaved |
| terminate | input | 1 | End the current burst |
| out_ready | input | 1 | Consumer accepts the offered column |
| col_valid | output | 1 | A column is offered |
| col_addr | output | COL_W | Offered column address |
| col_last | output | 1 | Offered column is the final beat of a fixed burst |

## Verification
The hardest cases to reach are those where a stall, a terminate and a restart fall on a burst's final beat or on the row wrap. Random pulses seldom land there. Directed runs place a full-row burst a few columns below the row end and stall a length-4 burst mid-way. They also restart an interleaved burst part-way through and change the length and ordering pins during a burst. A long random phase then mixes starts, terminates, ready drops and all eight codes. Each beat is checked against a bench model that computes the column from the start offset and beat index by modular arithmetic.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
  localparam logic [2:0] CODE_ONE   = 3'b000;
  localparam logic [2:0] CODE_TWO   = 3'b001;
  localparam logic [2:0] CODE_FOUR  = 3'b010;
  localparam logic [2:0] CODE_EIGHT = 3'b011;
  localparam logic [2:0] CODE_ROW   = 3'b111;

  // log2 of the fixed burst length; unused codes fold onto one column
  function automatic logic [1:0] len_log2(input logic [2:0] code);
    case (code)
      CODE_TWO:   len_log2 = 2'd1;
      CODE_FOUR:  len_log2 = 2'd2;
      CODE_EIGHT: len_log2 = 2'd3;
      default:    len_log2 = 2'd0;
    endcase
  endfunction

  function automatic logic is_row(input logic [2:0] code);
    is_row = (code == CODE_ROW);
  endfunction
endpackage

// File: rtl/cg_len_decode.sv
module cg_len_decode #(
  parameter int COL_W = 9
) (
  input  logic [2:0]       code,
  input  logic             ilv_req,
  output logic [COL_W-1:0] mask,
  output logic             full,
  output logic             ilv
);
  import colgen_pkg::*;

  logic [1:0] lg;

  always_comb begin
    lg   = len_log2(code);
    full = is_row(code);
    if (full) mask = '1;
    else      mask = (COL_W'(1) << lg) - COL_W'(1);
    // ordering only matters for fixed lengths above one column
    ilv  = ilv_req && !full && (lg != 2'd0);
  end
endmodule

// File: rtl/cg_addr_mux.sv
module cg_addr_mux #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] mask,
  input  logic             ilv,
  output logic [COL_W-1:0] addr
);
  logic [COL_W-1:0] sum;

  assign sum = base + beat;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    always_comb begin
      if (!mask[i])  addr[i] = base[i];
      else if (ilv) addr[i] = base[i] ^ beat[i];
      else          addr[i] = sum[i];
    end
  end
endmodule

// File: rtl/cg_beat_ctrl.sv
module cg_beat_ctrl #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             terminate,
  input  logic             out_ready,
  input  logic [COL_W-1:0] start_col,
  input  logic [COL_W-1:0] mask_d,
  input  logic             full_d,
  input  logic             ilv_d,
  output logic             active,
  output logic [COL_W-1:0] beat,
  output logic [COL_W-1:0] base_q,
  output logic [COL_W-1:0] mask_q,
  output logic             ilv_q,
  output logic             last
);
  logic full_q;

  assign last = active && !full_q && (beat == mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      beat   <= '0;
      base_q <= '0;
      mask_q <= '0;
      full_q <= 1'b0;
      ilv_q  <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      beat   <= '0;
      base_q <= start_col;
      mask_q <= mask_d;
      full_q <= full_d;
      ilv_q  <= ilv_d;
    end else if (terminate) begin
      active <= 1'b0;
    end else if (active && out_ready) begin
      if (last) active <= 1'b0;
      else      beat   <= beat + COL_W'(1);
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    active && !out_ready && !start && !terminate |=> active && $stable(beat));
  assert_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    terminate && !start |=> !active);
  assert_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    active && out_ready && last && !start && !terminate |=> !active);
  assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> active && (beat == '0));
  assert_cfg_R12: assert property (@(posedge clk) disable iff (!rst_n)
    active && !start |=> $stable(mask_q) && $stable(ilv_q) && $stable(base_q));
endmodule

// File: rtl/burst_colgen.sv
module burst_colgen #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       burst_len,
  input  logic             burst_ilv,
  input  logic             terminate,
  input  logic             out_ready,
  output logic             col_valid,
  output logic [COL_W-1:0] col_addr,
  output logic             col_last
);
  logic [COL_W-1:0] mask_d, mask_q, beat, base_q;
  logic             full_d, ilv_d, ilv_q, active, last;

  cg_len_decode #(.COL_W(COL_W)) u_dec (
    .code(burst_len), .ilv_req(burst_ilv),
    .mask(mask_d), .full(full_d), .ilv(ilv_d)
  );

  cg_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .terminate(terminate),
    .out_ready(out_ready), .start_col(start_col), .mask_d(mask_d),
    .full_d(full_d), .ilv_d(ilv_d), .active(active), .beat(beat),
    .base_q(base_q), .mask_q(mask_q), .ilv_q(ilv_q), .last(last)
  );

  cg_addr_mux #(.COL_W(COL_W)) u_mux (
    .base(base_q), .beat(beat), .mask(mask_q), .ilv(ilv_q), .addr(col_addr)
  );

  assign col_valid = active;
  assign col_last  = last;

  assert_last_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid);
  assert_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && out_ready && !col_last && !start && !terminate |=>
      ((col_addr & ~mask_q) == ($past(col_addr) & ~mask_q)));
  assert_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> col_valid && (col_addr == $past(start_col)));
  assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && !out_ready && !start && !terminate |=>
      $stable(col_addr) && $stable(col_last));
endmodule

// File: tb/tb_burst_colgen.sv
module tb_burst_colgen;
  localparam int COL_W = 9;
  localparam int ROW   = 1 << COL_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, burst_ilv = 0, terminate = 0, out_ready = 0;
  logic [COL_W-1:0] start_col = '0;
  logic [2:0] burst_len = '0;
  logic col_valid, col_last;
  logic [COL_W-1:0] col_addr;

  int checks = 0, fails = 0;
  bit done = 0;
  bit m_act = 0, m_ilv = 0;
  int m_start = 0, m_len = 1, m_k = 0;

  always #2.5 clk = ~clk;

  burst_colgen #(.COL_W(COL_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .burst_len(burst_len), .burst_ilv(burst_ilv), .terminate(terminate),
    .out_ready(out_ready), .col_valid(col_valid), .col_addr(col_addr),
    .col_last(col_last)
  );

  function automatic int len_of(input logic [2:0] c);
    case (c)
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      3'b111: return ROW;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col(input int s, input int len, input bit ilv, input int k);
    int lo, blk;
    if (len == ROW) return (s + k) % ROW;
    lo  = s % len;
    blk = s - lo;
    if (ilv) return blk + (lo ^ k);
    return blk + ((lo + k) % len);
  endfunction

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, got, exp);
    end
  endtask

  task automatic check_out(input string tag);
    bit el;
    string t;
    t = tag;
    if (t == "") t = (m_len == ROW) ? "R6" : (m_len == 1) ? "R5" : m_ilv ? "R4" : "R3";
    el = m_act && (m_len != ROW) && (m_k == m_len - 1);
    chk(t, "valid", int'(col_valid), int'(m_act));
    if (m_act) begin
      chk(t, "addr", int'(col_addr), exp_col(m_start, m_len, m_ilv, m_k));
      chk(t, "last", int'(col_last), int'(el));
    end
  endtask

  task automatic step(input bit st, input int col, input logic [2:0] code,
                      input bit typ, input bit rdy, input bit term, input string tag);
    bit el;
    start = st; start_col = COL_W'(col); burst_len = code;
    burst_ilv = typ; out_ready = rdy; terminate = term;
    @(posedge clk);
    el = m_act && (m_len != ROW) && (m_k == m_len - 1);
    if (st) begin
      m_act = 1; m_k = 0; m_start = col; m_len = len_of(code);
      m_ilv = typ && (m_len > 1) && (m_len < ROW);
    end else if (term) m_act = 0;
    else if (m_act && rdy) begin
      if (el) m_act = 0;
      else m_k = (m_k + 1) % ROW;
    end
    @(negedge clk);
    check_out(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1", "valid", int'(col_valid), 0);
    chk("R1", "last", int'(col_last), 0);
    step(0, 0, 3'b000, 0, 1, 0, "R1");
    // R2/R3: length 4, offset 2 -> 2,3,0,1 inside block
    step(1, 9'h0A6, 3'b010, 0, 1, 0, "R2");
    for (int i = 0; i < 4; i++) step(0, 0, 3'b000, 0, 1, 0, "R3");
    // R4: length 8 interleaved, offset 3
    step(1, 9'h13B, 3'b011, 1, 1, 0, "R4");
    for (int i = 0; i < 8; i++) step(0, 0, 3'b000, 0, 1, 0, "R4");
    // R5: single column, ordering ignored
    step(1, 9'h055, 3'b000, 1, 1, 0, "R5");
    step(0, 0, 3'b000, 0, 1, 0, "R5");
    // R6: full row across the row end
    step(1, 509, 3'b111, 1, 1, 0, "R6");
    for (int i = 0; i < 6; i++) step(0, 0, 3'b011, 0, 1, 0, "R6");
    // R9: terminate stops it
    step(0, 0, 3'b000, 0, 1, 1, "R9");
    step(0, 0, 3'b000, 0, 1, 0, "R9");
    // R8: stall mid-burst
    step(1, 9'h021, 3'b010, 0, 1, 0, "R8");
    step(0, 0, 3'b000, 0, 1, 0, "R8");
    for (int i = 0; i < 3; i++) step(0, 0, 3'b000, 0, 0, 0, "R8");
    for (int i = 0; i < 3; i++) step(0, 0, 3'b000, 0, 1, 0, "R7");
    // R10: restart part-way, while stalled
    step(1, 9'h1F2, 3'b011, 1, 1, 0, "R10");
    step(0, 0, 3'b000, 0, 1, 0, "R10");
    step(1, 9'h0C7, 3'b010, 0, 0, 0, "R10");
    for (int i = 0; i < 4; i++) step(0, 0, 3'b000, 0, 1, 0, "R10");
    // R11: unused codes act as one column
    step(1, 9'h0EE, 3'b101, 1, 1, 0, "R11");
    step(0, 0, 3'b000, 0, 1, 0, "R11");
    step(1, 9'h0EF, 3'b110, 0, 1, 0, "R11");
    step(0, 0, 3'b000, 0, 1, 0, "R11");
    // R12: pins change during burst
    step(1, 9'h104, 3'b011, 0, 1, 0, "R12");
    for (int i = 0; i < 8; i++) step(0, 0, 3'b111, 1, 1, 0, "R12");
    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit st, tm, rd, ty;
      st = ($urandom % 12) == 0;
      tm = ($urandom % 40) == 0;
      rd = ($urandom % 4) != 0;
      ty = $urandom % 2;
      step(st, int'($urandom % ROW), 3'($urandom % 8), ty, rd, tm, "");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule